// File: doc/BRIEF.md
# Calibrated IO Channel Freeze/Thaw Sequencer

This block drives the pad control lines of the one IO channel that also carries a delay-locked loop and on-chip termination. A freeze request walks the channel into its safe state in three fixed steps. A thaw request walks it back out. The thaw releases the DLL, starts termination calibration and waits for calibration to settle. Only then does it let go of the pads, in a fixed order.

Two kinds of wait are used. Short gaps of at least 40 ns are counted in system clock cycles, set by a parameter. The long calibration waits are counted in ticks of a slow internal oscillator. Each tick arrives as a one-cycle enable, `osc_tick`. While a sequence runs, the block raises `busy`, and any new request is dropped. Reset puts the channel in the frozen state.

Top module: `iochan_freeze_seq`

## Requirements
- R1: During and after reset, the outputs hold these frozen values: `slew_en_n`=0, `pullup_n`=0, `tristate_n`=0, `bushold_n`=0, `cfg_done`=0, `reg_rst`=1, `term_rst`=1, `dll_rst`=1, `cal_start`=0, `frozen`=1 and `busy`=0.
- R2: Freeze step one. A freeze request is sampled while the block is idle. At that clock edge, `slew_en_n`, `pullup_n` and `tristate_n` go low, and the other controls keep their values.
- R3: Freeze step two, one cycle after step one. `bushold_n` and `cfg_done` go low, and `reg_rst` and `term_rst` go high.
- R4: Freeze step three, one cycle after step two. `cal_start` goes low, `dll_rst` goes high and `frozen` goes high. At the same edge, `busy` returns low.
- R5: Thaw begins at the edge where an idle block samples a thaw request: `dll_rst` goes low at that edge. `cal_start` rises exactly GAP_CYCLES clock cycles later.
- R6: After `cal_start` rises, the block counts CAL_TICKS cycles in which `osc_tick` is high. Cycles with `osc_tick` low are not counted. At the edge that samples the last of those ticks, `bushold_n` and `cfg_done` go high and `term_rst` goes low.
- R7: After SETTLE_TICKS more counted ticks, `pullup_n` and `tristate_n` go high.
- R8: GAP_CYCLES cycles after R7, `reg_rst` goes low. GAP_CYCLES cycles after that, `slew_en_n` goes high and `frozen` goes low, and `busy` returns low at the same edge.
- R9: `busy` is high from the edge that accepts a request until the sequence ends. Requests sampled while `busy` is high are ignored: they neither change the running sequence nor start another one.
- R10: If freeze and thaw requests are sampled together while idle, the freeze sequence runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_tick | input | 1 | One-cycle enable per slow oscillator tick |
| freeze_req | input | 1 | Request to run the freeze sequence |
| thaw_req | input | 1 | Request to run the thaw sequence |
| slew_en_n | output | 1 | Slew enable, active low |
| pullup_n | output | 1 | Weak pull-up, active low |
| tristate_n | output | 1 | Pad tristate, active low |
| bushold_n | output | 1 | Bus-hold, active low |
| cfg_done | output | 1 | Configuration done, active high |
| reg_rst | output | 1 | IO register reset, active high |
| term_rst | output | 1 | Termination reset, active high |
| dll_rst | output | 1 | DLL reset, active high |
| cal_start | output | 1 | Termination calibration start, active high |
| frozen | output | 1 | Channel is in the frozen state |
| busy | output | 1 | A sequence is running |

## Verification
The hardest case to reach from the ports is tick counting when ticks are sparse. The block must count only cycles where `osc_tick` is high, and it must not count the tick that falls on the edge where `cal_start` rises. To reach this case, one thaw runs with a tick on every third cycle. A monitor counts, at each clock edge, exactly the ticks the block can see. The release edges are then compared against that count. Freeze requests are injected during the long calibration wait, and thaw requests during the freeze steps. This shows that a request arriving deep inside a sequence leaves the sequence untouched.

// File: rtl/iochan_freeze_pkg.sv
package iochan_freeze_pkg;

  typedef struct packed {
    logic slew_n;
    logic pull_n;
    logic tri_n;
    logic hold_n;
    logic cfg_done;
    logic reg_rst;
    logic term_rst;
    logic dll_rst;
    logic cal_start;
  } pad_ctrl_t;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_FZ_PADS,
    ST_FZ_HOLD,
    ST_TH_DLL,
    ST_TH_CAL,
    ST_TH_SETTLE,
    ST_TH_PADS,
    ST_TH_REGS
  } seq_state_t;

  function automatic pad_ctrl_t frozen_ctrl();
    pad_ctrl_t c;
    c.slew_n    = 1'b0;
    c.pull_n    = 1'b0;
    c.tri_n     = 1'b0;
    c.hold_n    = 1'b0;
    c.cfg_done  = 1'b0;
    c.reg_rst   = 1'b1;
    c.term_rst  = 1'b1;
    c.dll_rst   = 1'b1;
    c.cal_start = 1'b0;
    return c;
  endfunction

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

  function automatic int cnt_width(input int maxval);
    return $clog2(maxval + 1);
  endfunction

endpackage

// File: rtl/iochan_wait_timer.sv
module iochan_wait_timer #(
  parameter int CW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          en,
  output logic          expire,
  output logic [CW-1:0] count
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      count <= '0;
    else if (load)
      count <= load_val;
    else if (en && count != '0)
      count <= count - 1'b1;
  end

  assign expire = en && (count == CW'(1));

  // R6
  timer_no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(load) && $past(count) != '0) |-> (count <= $past(count)));

  // R6
  timer_idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !en) |=> $stable(count));

endmodule

// File: rtl/iochan_seq_fsm.sv
module iochan_seq_fsm
  import iochan_freeze_pkg::*;
#(
  parameter int CW           = 10,
  parameter int GAP_CYCLES   = 8,
  parameter int CAL_TICKS    = 1000,
  parameter int SETTLE_TICKS = 33
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          freeze_req,
  input  logic          thaw_req,
  input  logic          expire,
  output logic          load,
  output logic [CW-1:0] load_val,
  output logic          tick_mode,
  output pad_ctrl_t     ctrl,
  output logic          frozen,
  output logic          busy
);

  seq_state_t st_q, st_d;
  pad_ctrl_t  c_d;
  logic       mode_d;
  logic       frz_d;

  logic accept_frz;
  logic accept_thw;
  logic seq_end;

  assign busy       = (st_q != ST_IDLE);
  assign accept_frz = !busy && freeze_req;
  assign accept_thw = !busy && !freeze_req && thaw_req;
  assign seq_end    = busy && (st_d == ST_IDLE);

  always_comb begin
    st_d     = st_q;
    c_d      = ctrl;
    mode_d   = tick_mode;
    frz_d    = frozen;
    load     = 1'b0;
    load_val = '0;
    unique case (st_q)
      ST_IDLE: begin
        if (accept_frz) begin
          st_d     = ST_FZ_PADS;
          c_d.slew_n = 1'b0;
          c_d.pull_n = 1'b0;
          c_d.tri_n  = 1'b0;
        end else if (accept_thw) begin
          st_d        = ST_TH_DLL;
          c_d.dll_rst = 1'b0;
          load        = 1'b1;
          load_val    = CW'(GAP_CYCLES);
          mode_d      = 1'b0;
        end
      end
      ST_FZ_PADS: begin
        st_d         = ST_FZ_HOLD;
        c_d.hold_n   = 1'b0;
        c_d.cfg_done = 1'b0;
        c_d.reg_rst  = 1'b1;
        c_d.term_rst = 1'b1;
      end
      ST_FZ_HOLD: begin
        st_d          = ST_IDLE;
        c_d.cal_start = 1'b0;
        c_d.dll_rst   = 1'b1;
        frz_d         = 1'b1;
      end
      ST_TH_DLL: if (expire) begin
        st_d          = ST_TH_CAL;
        c_d.cal_start = 1'b1;
        load          = 1'b1;
        load_val      = CW'(CAL_TICKS);
        mode_d        = 1'b1;
      end
      ST_TH_CAL: if (expire) begin
        st_d         = ST_TH_SETTLE;
        c_d.hold_n   = 1'b1;
        c_d.cfg_done = 1'b1;
        c_d.term_rst = 1'b0;
        load         = 1'b1;
        load_val     = CW'(SETTLE_TICKS);
        mode_d       = 1'b1;
      end
      ST_TH_SETTLE: if (expire) begin
        st_d       = ST_TH_PADS;
        c_d.pull_n = 1'b1;
        c_d.tri_n  = 1'b1;
        load       = 1'b1;
        load_val   = CW'(GAP_CYCLES);
        mode_d     = 1'b0;
      end
      ST_TH_PADS: if (expire) begin
        st_d        = ST_TH_REGS;
        c_d.reg_rst = 1'b0;
        load        = 1'b1;
        load_val    = CW'(GAP_CYCLES);
        mode_d      = 1'b0;
      end
      ST_TH_REGS: if (expire) begin
        st_d       = ST_IDLE;
        c_d.slew_n = 1'b1;
        frz_d      = 1'b0;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      ctrl      <= frozen_ctrl();
      tick_mode <= 1'b0;
      frozen    <= 1'b1;
    end else begin
      st_q      <= st_d;
      ctrl      <= c_d;
      tick_mode <= mode_d;
      frozen    <= frz_d;
    end
  end

  // R5
  cal_after_dll_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctrl.cal_start) |-> !ctrl.dll_rst);

  // R6
  hold_after_cal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctrl.hold_n) |-> (ctrl.cal_start && !ctrl.dll_rst));

  // R7
  pads_after_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctrl.pull_n) |-> (ctrl.hold_n && ctrl.cfg_done && !ctrl.term_rst));

  // R8
  regs_after_pads_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ctrl.reg_rst) |-> (ctrl.pull_n && ctrl.tri_n));

  // R8
  slew_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctrl.slew_n) |-> (!ctrl.reg_rst && !frozen && !busy));

  // R4
  frozen_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frozen && !busy) |-> (ctrl.dll_rst && ctrl.reg_rst && ctrl.term_rst &&
                           !ctrl.cal_start && !ctrl.slew_n && !ctrl.hold_n));

  // R9
  frozen_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !seq_end) |=> $stable(frozen));

  // R2
  freeze_pads_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept_frz |=> (busy && !ctrl.slew_n && !ctrl.pull_n && !ctrl.tri_n));

endmodule

// File: rtl/iochan_freeze_seq.sv
module iochan_freeze_seq
  import iochan_freeze_pkg::*;
#(
  parameter int GAP_CYCLES   = 8,
  parameter int CAL_TICKS    = 1000,
  parameter int SETTLE_TICKS = 33
) (
  input  logic clk,
  input  logic rst_n,
  input  logic osc_tick,
  input  logic freeze_req,
  input  logic thaw_req,
  output logic slew_en_n,
  output logic pullup_n,
  output logic tristate_n,
  output logic bushold_n,
  output logic cfg_done,
  output logic reg_rst,
  output logic term_rst,
  output logic dll_rst,
  output logic cal_start,
  output logic frozen,
  output logic busy
);

  localparam int MAXV = max3(GAP_CYCLES, CAL_TICKS, SETTLE_TICKS);
  localparam int CW   = cnt_width(MAXV);

  logic          t_load;
  logic [CW-1:0] t_val;
  logic          t_en;
  logic          t_expire;
  logic [CW-1:0] t_count;
  logic          tick_mode;
  pad_ctrl_t     ctrl;

  assign t_en = tick_mode ? osc_tick : 1'b1;

  iochan_wait_timer #(.CW(CW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (t_load),
    .load_val (t_val),
    .en       (t_en),
    .expire   (t_expire),
    .count    (t_count)
  );

  iochan_seq_fsm #(
    .CW           (CW),
    .GAP_CYCLES   (GAP_CYCLES),
    .CAL_TICKS    (CAL_TICKS),
    .SETTLE_TICKS (SETTLE_TICKS)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .freeze_req (freeze_req),
    .thaw_req   (thaw_req),
    .expire     (t_expire),
    .load       (t_load),
    .load_val   (t_val),
    .tick_mode  (tick_mode),
    .ctrl       (ctrl),
    .frozen     (frozen),
    .busy       (busy)
  );

  assign slew_en_n  = ctrl.slew_n;
  assign pullup_n   = ctrl.pull_n;
  assign tristate_n = ctrl.tri_n;
  assign bushold_n  = ctrl.hold_n;
  assign cfg_done   = ctrl.cfg_done;
  assign reg_rst    = ctrl.reg_rst;
  assign term_rst   = ctrl.term_rst;
  assign dll_rst    = ctrl.dll_rst;
  assign cal_start  = ctrl.cal_start;

  // R6
  idle_timer_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !t_expire || t_count != CW'(1));

endmodule

// File: tb/iochan_freeze_seq_tb.sv
module iochan_freeze_seq_tb;

  localparam int GAP    = 8;
  localparam int CAL    = 1000;
  localparam int SETTLE = 33;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic osc_tick = 1'b0;
  logic freeze_req = 1'b0;
  logic thaw_req = 1'b0;
  logic slew_en_n, pullup_n, tristate_n, bushold_n, cfg_done;
  logic reg_rst, term_rst, dll_rst, cal_start, frozen, busy;

  int checks = 0;
  int failures = 0;
  int tick_period = 1;
  int tick_phase = 0;
  int tick_cnt = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  iochan_freeze_seq #(.GAP_CYCLES(GAP), .CAL_TICKS(CAL), .SETTLE_TICKS(SETTLE)) u_dut (
    .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick),
    .freeze_req(freeze_req), .thaw_req(thaw_req),
    .slew_en_n(slew_en_n), .pullup_n(pullup_n), .tristate_n(tristate_n),
    .bushold_n(bushold_n), .cfg_done(cfg_done), .reg_rst(reg_rst),
    .term_rst(term_rst), .dll_rst(dll_rst), .cal_start(cal_start),
    .frozen(frozen), .busy(busy)
  );

  always @(negedge clk) begin
    tick_phase <= tick_phase + 1;
    osc_tick   <= (tick_period != 0) && ((tick_phase % tick_period) == 0);
  end

  always @(posedge clk) if (osc_tick) tick_cnt <= tick_cnt + 1;

  task automatic finish_run();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      checks++;
      failures++;
      $display("FAIL watchdog: run hung, actual cycles=%0d expected below 150000", cycles);
      finish_run();
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [10:0] outs();
    return {slew_en_n, pullup_n, tristate_n, bushold_n, cfg_done,
            reg_rst, term_rst, dll_rst, cal_start, frozen, busy};
  endfunction

  localparam logic [10:0] FROZEN_OUTS = 11'b000_00_111_0_1_0;
  localparam logic [10:0] THAWED_OUTS = 11'b111_11_000_1_0_0;

  task automatic test_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1 during reset
    chk(outs() == FROZEN_OUTS, "R1", "outputs in reset", int'(outs()), int'(FROZEN_OUTS));
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 after reset with no request
    chk(outs() == FROZEN_OUTS, "R1", "outputs after reset", int'(outs()), int'(FROZEN_OUTS));
  endtask

  task automatic wait_until(input int sel, input bit val, output int n);
    n = 0;
    forever begin
      logic cur;
      case (sel)
        0: cur = cal_start;
        1: cur = bushold_n;
        2: cur = pullup_n;
        3: cur = reg_rst;
        default: cur = slew_en_n;
      endcase
      if (cur == val) break;
      @(negedge clk);
      n++;
    end
  endtask

  task automatic test_thaw(input int period, input bit poke_freeze);
    int n;
    int t0;
    tick_period = period;
    @(negedge clk);
    thaw_req = 1'b1;
    @(negedge clk);
    thaw_req = 1'b0;
    // R5 dll reset released at accept edge
    chk(!dll_rst && !cal_start && busy, "R5", "dll_rst low, cal_start low, busy",
        int'({dll_rst, cal_start, busy}), 1);
    wait_until(0, 1'b1, n);
    // R5 gap before calibration start
    chk(n == GAP, "R5", "cycles dll_rst->cal_start", n, GAP);
    t0 = tick_cnt;
    if (poke_freeze) begin
      freeze_req = 1'b1;
      @(negedge clk);
      freeze_req = 1'b0;
      // R9 freeze request ignored while busy
      chk(busy && bushold_n == 1'b0 && slew_en_n == 1'b0 && cal_start && !dll_rst,
          "R9", "sequence untouched by freeze_req", int'(outs()), 0);
    end
    wait_until(1, 1'b1, n);
    // R6 ticks counted during calibration wait
    chk(tick_cnt - t0 == CAL, "R6", "ticks before bus-hold release", tick_cnt - t0, CAL);
    // R6 release values
    chk(cfg_done && !term_rst && !pullup_n && busy, "R6", "cfg_done/term_rst/pullup at release",
        int'({cfg_done, term_rst, pullup_n, busy}), 4'b1001);
    t0 = tick_cnt;
    wait_until(2, 1'b1, n);
    // R7 settle ticks
    chk(tick_cnt - t0 == SETTLE, "R7", "ticks before pad release", tick_cnt - t0, SETTLE);
    // R7 tristate released together with pull-up
    chk(tristate_n && reg_rst, "R7", "tristate_n high, reg_rst still high",
        int'({tristate_n, reg_rst}), 2'b11);
    wait_until(3, 1'b0, n);
    // R8 gap before register reset release
    chk(n == GAP, "R8", "cycles pads->reg_rst low", n, GAP);
    chk(!slew_en_n && busy, "R8", "slew still low, busy", int'({slew_en_n, busy}), 1);
    wait_until(4, 1'b1, n);
    // R8 final step
    chk(n == GAP, "R8", "cycles reg_rst->slew high", n, GAP);
    chk(outs() == THAWED_OUTS, "R8", "thawed outputs", int'(outs()), int'(THAWED_OUTS));
    tick_period = 1;
  endtask

  task automatic test_freeze(input bit poke_thaw);
    @(negedge clk);
    freeze_req = 1'b1;
    @(negedge clk);
    freeze_req = 1'b0;
    // R2 step one
    chk({slew_en_n, pullup_n, tristate_n} == 3'b000 && bushold_n && cfg_done && cal_start && busy,
        "R2", "step one pads low, others held", int'(outs()), 0);
    if (poke_thaw) thaw_req = 1'b1;
    @(negedge clk);
    thaw_req = 1'b0;
    // R3 step two
    chk(!bushold_n && !cfg_done && reg_rst && term_rst && cal_start && !dll_rst && busy,
        "R3", "step two", int'(outs()), 0);
    @(negedge clk);
    // R4 step three
    chk(outs() == FROZEN_OUTS, "R4", "frozen outputs", int'(outs()), int'(FROZEN_OUTS));
    repeat (GAP + 3) @(negedge clk);
    // R9 thaw request during freeze left no trace
    chk(outs() == FROZEN_OUTS, "R9", "still frozen after ignored thaw", int'(outs()), int'(FROZEN_OUTS));
  endtask

  task automatic test_both();
    @(negedge clk);
    freeze_req = 1'b1;
    thaw_req   = 1'b1;
    @(negedge clk);
    freeze_req = 1'b0;
    thaw_req   = 1'b0;
    // R10 freeze wins: dll_rst untouched, pads low
    chk(!slew_en_n && !pullup_n && !dll_rst && busy, "R10", "freeze step one taken",
        int'({slew_en_n, pullup_n, dll_rst, busy}), 1);
    repeat (2) @(negedge clk);
    chk(outs() == FROZEN_OUTS, "R10", "frozen after simultaneous requests",
        int'(outs()), int'(FROZEN_OUTS));
  endtask

  initial begin
    test_reset();
    test_thaw(1, 1'b0);
    test_freeze(1'b1);
    test_thaw(3, 1'b1);
    test_both();
    finish_run();
  end

endmodule